// File: doc/BRIEF.md
# Asynchronous static RAM controller

This block connects a clocked request port to an external asynchronous static RAM of 2^ADDR_W words by DATA_W bits (18 and 8 by default). The RAM has active-low chip select, output enable and write strobe pins and one shared data bus. The bus appears here as a separate output value, an output-enable and an input value, and the pad tri-state is built from them. The user presents a request with address, direction and write data and holds it until `req_ready` is high at a clock edge. Each read returns its data with a one-cycle `rd_valid` pulse.

Every strobe phase is a whole number of clock cycles, and each count is a parameter. The user derives the counts from the clock period and the RAM speed grade: read access, write setup, write pulse, read-to-drive turnaround and chip-select wake-up. The RAM writes only while chip select and write strobe are both low. The controller holds output enable high for the whole of every write, so the shorter write-pulse minimum applies and the bus never has two drivers. After IDLE_LIM idle cycles with no request, chip select is released and the RAM drops into standby. The next access then waits longer so that the chip-select access time is met.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: A read with no wake-up holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for RD_CYC cycles. It samples `mem_dq_i` at the end of the last of those cycles. In the next cycle it shows that byte on `rd_data`, with `rd_valid`=1 for exactly one cycle.
- R3: A write first drives `mem_dq_o` with `mem_dq_oe`=1, `mem_ce_n`=0 and `mem_we_n`=1 for SU_CYC cycles. It then keeps the data driven for one more cycle after `mem_we_n` returns to 1. The driven data does not change at any point in the write.
- R4: A write holds `mem_we_n`=0 for exactly WR_CYC consecutive cycles, and `mem_oe_n` is 1 whenever `mem_we_n` is 0.
- R5: After the read phase, `mem_oe_n` is 1 for TA_CYC cycles before the controller accepts another request. `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R6: `req_ready` is 1 only while no access is in progress. A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. While `req_ready` is 0, `req_valid` and the request fields have no effect on the RAM pins.
- R7: After IDLE_LIM consecutive idle cycles with chip select low, `mem_ce_n` rises to 1 (standby) and stays there until the next request. Reset also leaves the RAM in standby. In standby `mem_oe_n` and `mem_we_n` are 1 and the bus is not driven.
- R8: An access taken while `mem_ce_n` is 1 lengthens its first phase by WAKE_CYC cycles. That phase is the read phase for a read and the setup phase for a write.
- R9: `mem_addr` equals the request address from the first cycle of an access to its last, and does not change during the access.
- R10: The pins follow the RAM mode encoding. Chip select high means deselected. Chip select low with write strobe low means write. Chip select low with write strobe high and output enable low means read. `mem_we_n` is never 0 while `mem_ce_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| rd_valid | output | 1 | One-cycle pulse, `rd_data` holds read result |
| rd_data | output | DATA_W | Read result |
| mem_addr | output | ADDR_W | RAM address pins |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_o | output | DATA_W | Value to drive on the RAM data bus |
| mem_dq_oe | output | 1 | Drive enable for the RAM data bus |
| mem_dq_i | input | DATA_W | Value seen on the RAM data bus |

## Verification
A wrong phase counter or state shows up in the first cycle that a strobe, the drive enable or `req_ready` differs from the expected schedule. The bench compares every pin on every clock, so a one-cycle shortening of a read, write pulse or turnaround fails at that cycle. The RAM model returns an inverted byte unless address, output enable and chip select have been stable long enough. A missing wake-up delay or a premature sample therefore appears on `rd_data` one cycle after the sample. A lost standby count appears as `mem_ce_n` at the wrong level in the idle cycle numbered IDLE_LIM.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 8,
  parameter int RD_CYC   = 2,
  parameter int WR_CYC   = 2,
  parameter int SU_CYC   = 1,
  parameter int TA_CYC   = 1,
  parameter int WAKE_CYC = 2,
  parameter int IDLE_LIM = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int CW = $clog2(RD_CYC + WR_CYC + SU_CYC + TA_CYC + WAKE_CYC + 1) + 1;
  localparam int IW = $clog2(IDLE_LIM + 1) + 1;
  localparam logic [CW-1:0] RD_N   = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WR_N   = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] SU_N   = CW'(SU_CYC - 1);
  localparam logic [CW-1:0] TA_N   = CW'(TA_CYC - 1);
  localparam logic [CW-1:0] WAKE_N = CW'(WAKE_CYC);
  localparam logic [IW-1:0] IDLE_N = IW'(IDLE_LIM - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_TURN, ST_WSET, ST_WPULSE, ST_WHOLD
  } phase_t;

  phase_t          phase;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   idle_cnt;

  wire             take     = req_valid && req_ready;
  wire             cnt_done = (cnt == '0);
  wire  [CW-1:0]   wake_add = mem_ce_n ? WAKE_N : '0;

  assign req_ready = (phase == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= ST_IDLE;
      cnt       <= '0;
      idle_cnt  <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      unique case (phase)
        ST_IDLE: begin
          if (take) begin
            mem_addr <= req_addr;
            mem_ce_n <= 1'b0;
            idle_cnt <= '0;
            if (req_write) begin
              phase     <= ST_WSET;
              cnt       <= SU_N + wake_add;
              mem_dq_o  <= req_wdata;
              mem_dq_oe <= 1'b1;
            end else begin
              phase    <= ST_RD;
              cnt      <= RD_N + wake_add;
              mem_oe_n <= 1'b0;
            end
          end else if (!mem_ce_n) begin
            if (idle_cnt == IDLE_N) mem_ce_n <= 1'b1;
            else                    idle_cnt <= idle_cnt + 1'b1;
          end
        end
        ST_RD: begin
          if (cnt_done) begin
            rd_data  <= mem_dq_i;
            rd_valid <= 1'b1;
            mem_oe_n <= 1'b1;
            phase    <= ST_TURN;
            cnt      <= TA_N;
          end else cnt <= cnt - 1'b1;
        end
        ST_TURN: begin
          if (cnt_done) phase <= ST_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        ST_WSET: begin
          if (cnt_done) begin
            mem_we_n <= 1'b0;
            phase    <= ST_WPULSE;
            cnt      <= WR_N;
          end else cnt <= cnt - 1'b1;
        end
        ST_WPULSE: begin
          if (cnt_done) begin
            mem_we_n <= 1'b1;
            phase    <= ST_WHOLD;
          end else cnt <= cnt - 1'b1;
        end
        ST_WHOLD: begin
          mem_dq_oe <= 1'b0;
          phase     <= ST_IDLE;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assert_we_oe_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_drive_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));

  assert_we_needs_ce_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

  assert_wdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

  assert_standby_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe && req_ready));

  assert_ready_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18, DW = 8;
  localparam int P_RD = 2, P_WR = 3, P_SU = 1, P_TA = 2, P_WAKE = 2, P_IDLE = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic req_valid = 0, req_ready, req_write = 0, rd_valid;
  logic [AW-1:0] req_addr = '0, mem_addr;
  logic [DW-1:0] req_wdata = '0, rd_data, mem_dq_o, mem_dq_i;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;

  sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(P_RD), .WR_CYC(P_WR),
    .SU_CYC(P_SU), .TA_CYC(P_TA), .WAKE_CYC(P_WAKE), .IDLE_LIM(P_IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  int checks = 0, fails = 0;
  bit running = 0, done = 0;

  // RAM model: returns an inverted byte when access time is not met
  logic [7:0] ram [int];
  logic [7:0] ram_q = '0;
  int ce_age = 0, aa_age = 0;
  logic [AW-1:0] last_a = '0;
  wire ram_drive = !mem_ce_n && !mem_oe_n && mem_we_n;
  wire [DW-1:0] bus = ram_drive ? ram_q : (mem_dq_oe ? mem_dq_o : 8'hFF);
  assign mem_dq_i = bus;

  function automatic logic [7:0] init_val(input logic [AW-1:0] a);
    return a[7:0] ^ {a[17:16], a[13:8]} ^ 8'h3C;
  endfunction

  function automatic logic [7:0] ram_get(input logic [AW-1:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : init_val(a);
  endfunction

  always @(negedge clk) begin
    ce_age = mem_ce_n ? 0 : ce_age + 1;
    if (mem_ce_n || mem_oe_n) aa_age = 0;
    else if (mem_addr != last_a) aa_age = 1;
    else aa_age = aa_age + 1;
    last_a = mem_addr;
    ram_q = (aa_age >= P_RD && ce_age >= P_RD + P_WAKE) ? ram_get(mem_addr) : ~ram_get(mem_addr);
    if (!mem_ce_n && !mem_we_n) ram[int'(mem_addr)] = bus;
  end

  // Reference schedule model
  typedef struct packed {
    logic ce, oe, we, drv, rdy, rv, chk_a;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [31:0] tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int idle_k = 0;
  bit sb = 1;
  logic [7:0] model_mem [int];

  function automatic exp_t mk(input logic ce, oe, we, drv, rdy, rv, chk_a,
                              input logic [AW-1:0] a, input logic [DW-1:0] d,
                              input logic [31:0] tag);
    exp_t e;
    e.ce = ce; e.oe = oe; e.we = we; e.drv = drv; e.rdy = rdy; e.rv = rv;
    e.chk_a = chk_a; e.a = a; e.d = d; e.tag = tag;
    return e;
  endfunction

  function automatic logic [7:0] model_get(input logic [AW-1:0] a);
    return model_mem.exists(int'(a)) ? model_mem[int'(a)] : init_val(a);
  endfunction

  task automatic build(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic wake);
    int first;
    first = (w ? P_SU : P_RD) + (wake ? P_WAKE : 0);
    if (w) begin
      for (int i = 0; i < first; i++) q.push_back(mk(0,1,1,1,0,0,1,a,d, wake ? "R8" : "R3"));
      for (int i = 0; i < P_WR; i++)  q.push_back(mk(0,1,0,1,0,0,1,a,d,"R4"));
      q.push_back(mk(0,1,1,1,0,0,1,a,d,"R3"));
      model_mem[int'(a)] = d;
    end else begin
      for (int i = 0; i < first; i++) q.push_back(mk(0,0,1,0,0,0,1,a,'0, wake ? "R8" : "R2"));
      for (int i = 0; i < P_TA; i++)  q.push_back(mk(0,1,1,0,0,(i == 0),1,a,model_get(a), i == 0 ? "R2" : "R5"));
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && running) begin
      logic bad;
      checks++;
      // R6 ready, R10 strobe encoding, R9 address hold, R3 data hold
      bad = (mem_ce_n !== cur.ce) || (mem_oe_n !== cur.oe) || (mem_we_n !== cur.we) ||
            (mem_dq_oe !== cur.drv) || (req_ready !== cur.rdy) || (rd_valid !== cur.rv) ||
            (cur.chk_a && mem_addr !== cur.a) || (cur.drv && mem_dq_o !== cur.d) ||
            (cur.rv && rd_data !== cur.d);
      if (!mem_we_n && mem_ce_n) bad = 1;  // R10
      if (bad) begin
        fails++;
        $display("FAIL %s t=%0t act ce%b oe%b we%b drv%b rdy%b rv%b a=%h dq=%h rd=%h exp ce%b oe%b we%b drv%b rdy%b rv%b a=%h d=%h",
          cur.tag, $time, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rd_valid,
          mem_addr, mem_dq_o, rd_data, cur.ce, cur.oe, cur.we, cur.drv, cur.rdy, cur.rv, cur.a, cur.d);
      end
      if (ram_drive && mem_dq_oe) begin
        checks++; fails++;
        $display("FAIL R5 bus contention act drv=1 exp drv=0");
      end
      if (cur.rdy && req_valid) begin
        build(req_write, req_addr, req_wdata, cur.ce);
        sb = 0;
      end
      if (q.size() > 0) begin
        cur = q.pop_front();
        idle_k = -1;
      end else begin
        idle_k++;
        cur = mk((sb || idle_k >= P_IDLE), 1, 1, 0, 1, 0, 0, '0, '0, "R7");
      end
    end
  end

  task automatic issue(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit acc;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    acc = 0;
    while (!acc) begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #1;
    end
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    for (int i = 0; i < n; i++) begin
      req_addr = AW'(i * 37 + 5); req_write = i[0]; req_wdata = 8'(i * 13);  // R6 junk while not valid
      @(posedge clk); #1;
    end
  endtask

  initial begin
    logic [AW-1:0] lfsr;
    cur = mk(1,1,1,0,1,0,0,'0,'0,"R7");
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R1 reset state
    if (mem_ce_n !== 1 || mem_oe_n !== 1 || mem_we_n !== 1 || mem_dq_oe !== 0 || rd_valid !== 0 || req_ready !== 1) begin
      fails++;
      $display("FAIL R1 act ce%b oe%b we%b drv%b rv%b rdy%b exp 1 1 1 0 0 1",
        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid, req_ready);
    end
    @(posedge clk); #1; rst_n = 1; running = 1;
    issue(1, 18'h00000, 8'h11);
    issue(0, 18'h00000, 8'h00);
    issue(1, 18'h3FFFF, 8'hC3);
    issue(0, 18'h3FFFF, 8'h00);
    issue(0, 18'h12345, 8'h00);
    idle(3);
    issue(1, 18'h00100, 8'h5A);
    idle(P_IDLE + 3);
    issue(0, 18'h00100, 8'h00);
    lfsr = 18'h2A5F1;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[16:0], lfsr[17] ^ lfsr[10]};
      if (i % 5 == 2) idle(P_IDLE - 2 + (i % 4) * 2);
      issue(lfsr[0], {lfsr[17:4], 4'(i % 4)}, lfsr[11:4]);
    end
    idle(P_IDLE + 4);
    issue(0, 18'h00000, 8'h00);
    idle(12);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule